// File: doc/BRIEF.md
# Priority interrupt acknowledge controller

This block sits beside a processor core and decides when to request an interrupt and which vector to return when the core acknowledges it. Sources post vectors into a 256-entry pending set. The unit tracks the vectors already in service. It also holds a task-priority threshold and a configuration register that carries the spurious vector. An interrupt line is raised whenever the best pending vector may pre-empt both the current task priority and the work already in service.

The core answers the interrupt line with a one-cycle acknowledge pulse. One cycle later the unit returns a vector. If the request is still deliverable, it returns the winning vector and moves that vector from pending to in-service. In these cases it returns the programmed spurious vector and changes no state:

- the unit is disabled;
- the request was masked in the meantime, for example because the task priority was raised between the request and the acknowledge.

An end-of-interrupt write retires the highest in-service vector. The task priority can be loaded from two independent write paths. A parameter selects one of two layouts for the configuration register.

Top module: `irq_ack_ctrl`

## Requirements
- R1: The priority class of a vector is bits 7:4. `intr_o` is high exactly when all of the following hold: the unit is enabled, a vector is pending, and the class of the highest pending vector is strictly greater than both the task-priority class (`tpr_o[7:4]`) and the class of the highest in-service vector (taken as 0 when none is in service).
- R2: An acknowledge sampled while `intr_o` is high gives `ack_valid_o` = 1 and `ack_vec_o` = the highest pending vector on the following cycle. At the same edge, that vector leaves the pending set and enters the in-service set.
- R3: An acknowledge sampled while the unit is enabled but no vector is deliverable returns `spur_vec_o`, for example after a task-priority raise masks the request. The pending and in-service sets are left unchanged.
- R4: While the enable bit is 0, `intr_o` stays low and every acknowledge returns the spurious vector.
- R5: A real interrupt whose vector equals the spurious vector is granted like any other. Its in-service bit then blocks every vector of the same or a lower class until an end-of-interrupt clears it.
- R6: A write with `wr_sel_i` = 2 (end of interrupt) clears only the highest-numbered in-service vector. With nothing in service it has no effect.
- R7: `wr_sel_i` = 0 on the main port loads `tpr_o` from `wr_data_i[7:0]`. `tpr_b_we_i` loads it from `tpr_b_data_i`. If both write in the same cycle, the main port's value is kept.
- R8: `wr_sel_i` = 1 writes the configuration register. The vector is taken from data bits 7:0, the enable bit from bit 8 and the focus-check-disable bit from bit 9. With `VEC_ALL_WR` = 1, all 8 vector bits are writable, and the focus bit reads 0 and ignores writes.
- R9: With `VEC_ALL_WR` = 0, only vector bits 7:4 are writable. Bits 3:0 read 1 and ignore writes, and the focus bit is writable.
- R10: After reset, `intr_o` = 0, `tpr_o` = 0, `spur_vec_o` = 0xFF, `sw_en_o` = 0 and `focus_dis_o` = 0. Both sets are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Post a vector to the pending set |
| req_vec_i | input | 8 | Vector being posted |
| wr_en_i | input | 1 | Main write port strobe |
| wr_sel_i | input | 2 | 0 task priority, 1 configuration, 2 end of interrupt, 3 unused |
| wr_data_i | input | 16 | Main write data |
| tpr_b_we_i | input | 1 | Second task-priority write strobe |
| tpr_b_data_i | input | 8 | Second task-priority write data |
| ack_i | input | 1 | Acknowledge pulse from the core |
| intr_o | output | 1 | Interrupt request to the core |
| ack_valid_o | output | 1 | Returned vector is valid |
| ack_vec_o | output | 8 | Returned vector |
| tpr_o | output | 8 | Current task priority |
| spur_vec_o | output | 8 | Spurious vector field |
| sw_en_o | output | 1 | Enable bit |
| focus_dis_o | output | 1 | Focus-check-disable bit |

## Verification
`intr_o` is decoded directly from registered state. It therefore reflects a posted vector, a register write or an end of interrupt right after the edge that accepts it. `ack_valid_o` and `ack_vec_o` appear one cycle after the edge that samples `ack_i`. Stimulus is applied at the falling edge. A behavioural model advances at each rising edge, and all outputs are compared at the next falling edge, so every result is read in exactly the cycle it is due.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int unsigned NUM_VEC = 256;
  localparam int unsigned VEC_W   = $clog2(NUM_VEC);
  localparam int unsigned CLS_W   = 4;
  localparam int unsigned WR_W    = 16;

  localparam int unsigned SVR_EN_BIT    = 8;
  localparam int unsigned SVR_FOCUS_BIT = 9;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  typedef enum logic [1:0] {
    SEL_TPR  = 2'd0,
    SEL_SVR  = 2'd1,
    SEL_EOI  = 2'd2,
    SEL_RSVD = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 256,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] bits_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  // highest set index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end

  always_comb begin
    if (any_o) AST_IDX_IS_SET: assert (bits_i[idx_o]); // R2
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ack_pkg::*;
#(
  parameter bit VEC_ALL_WR = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [WR_W-1:0] wr_data_i,
  input  logic            tpr_b_we_i,
  input  vec_t            tpr_b_data_i,
  output vec_t            tpr_o,
  output vec_t            spur_vec_o,
  output logic            sw_en_o,
  output logic            focus_dis_o
);
  logic tpr_a_we, svr_we;
  vec_t tpr_q, spur_q, spur_d;
  logic en_q, focus_q, focus_d;

  assign tpr_a_we = wr_en_i && (wr_sel_i == SEL_TPR);
  assign svr_we   = wr_en_i && (wr_sel_i == SEL_SVR);

  generate
    if (VEC_ALL_WR) begin : g_full
      assign spur_d  = wr_data_i[VEC_W-1:0];
      assign focus_d = 1'b0;
    end else begin : g_legacy
      assign spur_d  = {wr_data_i[VEC_W-1:CLS_W], {CLS_W{1'b1}}};
      assign focus_d = wr_data_i[SVR_FOCUS_BIT];
    end
  endgenerate

  // main port takes precedence over the second path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_q <= '0;
    end else if (tpr_a_we) begin
      tpr_q <= wr_data_i[VEC_W-1:0];
    end else if (tpr_b_we_i) begin
      tpr_q <= tpr_b_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spur_q  <= '1;
      en_q    <= 1'b0;
      focus_q <= 1'b0;
    end else if (svr_we) begin
      spur_q  <= spur_d;
      en_q    <= wr_data_i[SVR_EN_BIT];
      focus_q <= focus_d;
    end
  end

  assign tpr_o       = tpr_q;
  assign spur_vec_o  = spur_q;
  assign sw_en_o     = en_q;
  assign focus_dis_o = focus_q;

  AST_TPR_A_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tpr_a_we && tpr_b_we_i) |=> (tpr_o == $past(wr_data_i[VEC_W-1:0]))); // R7

  generate
    if (VEC_ALL_WR) begin : g_chk_full
      AST_FOCUS_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        svr_we |=> !focus_dis_o); // R8
    end else begin : g_chk_legacy
      AST_LOW_NIBBLE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        svr_we |=> (spur_vec_o[CLS_W-1:0] == {CLS_W{1'b1}})); // R9
    end
  endgenerate
endmodule

// File: rtl/irq_vec_state.sv
module irq_vec_state
  import irq_ack_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  vec_t req_vec_i,
  input  logic ack_i,
  input  logic eoi_i,
  input  cls_t tpr_cls_i,
  input  logic sw_en_i,
  output logic intr_o,
  output logic grant_o,
  output vec_t grant_vec_o
);
  logic [NUM_VEC-1:0] pend_q, pend_d, isr_q, isr_d;
  logic pend_any, isr_any, deliverable, grant;
  vec_t hp_vec, hi_isr;
  cls_t isr_cls, hp_cls;

  irq_prio_enc #(.N(NUM_VEC)) i_pend_enc (
    .bits_i (pend_q),
    .any_o  (pend_any),
    .idx_o  (hp_vec)
  );

  irq_prio_enc #(.N(NUM_VEC)) i_isr_enc (
    .bits_i (isr_q),
    .any_o  (isr_any),
    .idx_o  (hi_isr)
  );

  assign hp_cls      = hp_vec[VEC_W-1:VEC_W-CLS_W];
  assign isr_cls     = isr_any ? hi_isr[VEC_W-1:VEC_W-CLS_W] : '0;
  assign deliverable = pend_any && (hp_cls > tpr_cls_i) && (hp_cls > isr_cls);
  assign intr_o      = sw_en_i && deliverable;
  assign grant       = ack_i && intr_o;

  always_comb begin
    pend_d = pend_q;
    if (grant) pend_d[hp_vec] = 1'b0;
    if (req_valid_i) pend_d[req_vec_i] = 1'b1;
  end

  always_comb begin
    isr_d = isr_q;
    if (eoi_i && isr_any) isr_d[hi_isr] = 1'b0;
    if (grant) isr_d[hp_vec] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      pend_q <= pend_d;
      isr_q  <= isr_d;
    end
  end

  assign grant_o     = grant;
  assign grant_vec_o = hp_vec;

  AST_SPUR_ISR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !grant && !eoi_i) |=> (isr_q == $past(isr_q))); // R3
  AST_SPUR_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !grant && !req_valid_i) |=> (pend_q == $past(pend_q))); // R3
  AST_GRANT_SETS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant |=> isr_q[$past(hp_vec)]); // R2
  AST_GRANT_CLEARS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant && !req_valid_i) |=> !pend_q[$past(hp_vec)]); // R2
  AST_EOI_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_any && !ack_i) |=> ($countones(isr_q) + 1 == $countones($past(isr_q)))); // R6
  AST_EOI_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !isr_any && !ack_i) |=> (isr_q == '0)); // R6
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter bit VEC_ALL_WR = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [7:0]      req_vec_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [WR_W-1:0] wr_data_i,
  input  logic            tpr_b_we_i,
  input  logic [7:0]      tpr_b_data_i,
  input  logic            ack_i,
  output logic            intr_o,
  output logic            ack_valid_o,
  output logic [7:0]      ack_vec_o,
  output logic [7:0]      tpr_o,
  output logic [7:0]      spur_vec_o,
  output logic            sw_en_o,
  output logic            focus_dis_o
);
  vec_t tpr, spur_vec, grant_vec, ack_vec_q;
  logic sw_en, focus_dis, eoi, grant, ack_valid_q;

  assign eoi = wr_en_i && (wr_sel_i == SEL_EOI);

  irq_cfg_regs #(.VEC_ALL_WR(VEC_ALL_WR)) i_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .tpr_b_we_i   (tpr_b_we_i),
    .tpr_b_data_i (tpr_b_data_i),
    .tpr_o        (tpr),
    .spur_vec_o   (spur_vec),
    .sw_en_o      (sw_en),
    .focus_dis_o  (focus_dis)
  );

  irq_vec_state i_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_vec_i   (req_vec_i),
    .ack_i       (ack_i),
    .eoi_i       (eoi),
    .tpr_cls_i   (tpr[VEC_W-1:VEC_W-CLS_W]),
    .sw_en_i     (sw_en),
    .intr_o      (intr_o),
    .grant_o     (grant),
    .grant_vec_o (grant_vec)
  );

  // vector returned one cycle after the acknowledge is sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_q <= 1'b0;
      ack_vec_q   <= '0;
    end else begin
      ack_valid_q <= ack_i;
      if (ack_i) ack_vec_q <= grant ? grant_vec : spur_vec;
    end
  end

  assign ack_valid_o = ack_valid_q;
  assign ack_vec_o   = ack_vec_q;
  assign tpr_o       = tpr;
  assign spur_vec_o  = spur_vec;
  assign sw_en_o     = sw_en;
  assign focus_dis_o = focus_dis;

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> ack_valid_o); // R2
  AST_DIS_SPUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !sw_en) |=> (ack_vec_o == $past(spur_vec))); // R4
  AST_DIS_NO_INTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_en_o) |-> !intr_o); // R4
endmodule

// File: tb/test_irq_ack_ctrl.sv
`timescale 1ns/1ps
module test_irq_ack_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, wr_en = 0, tpr_b_we = 0, ack = 0;
  logic [7:0]  req_vec = 0, tpr_b_data = 0;
  logic [1:0]  wr_sel = 0;
  logic [15:0] wr_data = 0;

  logic intr, ack_valid, sw_en, focus_dis;
  logic [7:0] ack_vec, tpr, spur_vec;
  logic l_intr, l_ack_valid, l_sw_en, l_focus;
  logic [7:0] l_ack_vec, l_tpr, l_spur;

  irq_ack_ctrl #(.VEC_ALL_WR(1'b1)) i_irq_ack_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vec_i(req_vec),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .tpr_b_we_i(tpr_b_we), .tpr_b_data_i(tpr_b_data), .ack_i(ack),
    .intr_o(intr), .ack_valid_o(ack_valid), .ack_vec_o(ack_vec), .tpr_o(tpr),
    .spur_vec_o(spur_vec), .sw_en_o(sw_en), .focus_dis_o(focus_dis));

  irq_ack_ctrl #(.VEC_ALL_WR(1'b0)) i_irq_ack_ctrl_legacy (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vec_i(req_vec),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .tpr_b_we_i(tpr_b_we), .tpr_b_data_i(tpr_b_data), .ack_i(ack),
    .intr_o(l_intr), .ack_valid_o(l_ack_valid), .ack_vec_o(l_ack_vec), .tpr_o(l_tpr),
    .spur_vec_o(l_spur), .sw_en_o(l_sw_en), .focus_dis_o(l_focus));

  int n_chk = 0, n_fail = 0;

  // reference model state
  bit [255:0] m_pend = '0, m_isr = '0;
  int m_tpr = 0, m_spur = 255, m_lspur = 255;
  bit m_en = 0, m_focus = 0, m_lfocus = 0;
  bit m_ack_valid = 0;
  int m_ack_vec = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int top_bit(input bit [255:0] b);
    int r = -1;
    for (int i = 0; i < 256; i++) if (b[i]) r = i;
    return r;
  endfunction

  function automatic bit exp_intr();
    int hp = top_bit(m_pend);
    int hi = top_bit(m_isr);
    int icls = (hi >= 0) ? hi / 16 : 0;
    return m_en && hp >= 0 && (hp / 16) > (m_tpr / 16) && (hp / 16) > icls;
  endfunction

  task automatic model_edge();
    int hp = top_bit(m_pend);
    int hi = top_bit(m_isr);
    bit gnt = ack && exp_intr();
    m_ack_valid = ack;
    if (ack) m_ack_vec = gnt ? hp : m_spur;
    if (wr_en && wr_sel == 2'd2 && hi >= 0) m_isr[hi] = 1'b0;
    if (gnt) begin
      m_pend[hp] = 1'b0;
      m_isr[hp] = 1'b1;
    end
    if (req_valid) m_pend[req_vec] = 1'b1;
    if (wr_en && wr_sel == 2'd0) m_tpr = int'(wr_data[7:0]);
    else if (tpr_b_we) m_tpr = int'(tpr_b_data);
    if (wr_en && wr_sel == 2'd1) begin
      m_spur = int'(wr_data[7:0]);
      m_lspur = int'({wr_data[7:4], 4'hF});
      m_en = wr_data[8];
      m_focus = 1'b0;
      m_lfocus = wr_data[9];
    end
  endtask

  task automatic compare();
    check(intr === exp_intr(), "R1 intr", int'(intr), int'(exp_intr()));
    check(ack_valid === m_ack_valid, "R2 ack_valid", int'(ack_valid), int'(m_ack_valid));
    if (m_ack_valid) check(ack_vec === m_ack_vec[7:0], "R2 ack_vec", int'(ack_vec), m_ack_vec);
    check(tpr === m_tpr[7:0], "R7 tpr", int'(tpr), m_tpr);
    check(spur_vec === m_spur[7:0] && sw_en === m_en && focus_dis === m_focus,
          "R8 svr", int'({focus_dis, sw_en, spur_vec}), int'({m_focus, m_en, m_spur[7:0]}));
    check(l_spur === m_lspur[7:0] && l_focus === m_lfocus, "R9 legacy svr",
          int'({l_focus, l_spur}), int'({m_lfocus, m_lspur[7:0]}));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    req_valid = 0; wr_en = 0; tpr_b_we = 0; ack = 0;
  endtask

  task automatic do_req(input logic [7:0] v);
    req_valid = 1; req_vec = v; step();
  endtask
  task automatic do_ack();
    ack = 1; step();
  endtask
  task automatic do_wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; step();
  endtask
  task automatic do_tpr_b(input logic [7:0] d);
    tpr_b_we = 1; tpr_b_data = d; step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R10 reset state
    check(intr === 1'b0 && tpr === 8'h00, "R10 intr/tpr", int'({intr, tpr}), 0);
    check(spur_vec === 8'hFF && sw_en === 0 && focus_dis === 0, "R10 svr",
          int'({focus_dis, sw_en, spur_vec}), 'hFF);
    check(l_spur === 8'hFF && l_focus === 0, "R10 legacy svr", int'({l_focus, l_spur}), 'hFF);

    // R4 disabled
    do_req(8'h45);
    check(intr === 1'b0, "R4 intr while disabled", int'(intr), 0);
    do_ack();
    check(ack_valid === 1 && ack_vec === 8'hFF, "R4 spurious while disabled", int'(ack_vec), 'hFF);

    // R8 / R9 layout
    do_wr(2'd1, 16'h0330);
    check(spur_vec === 8'h30 && sw_en === 1 && focus_dis === 0, "R8 full layout",
          int'({focus_dis, sw_en, spur_vec}), 'h130);
    check(l_spur === 8'h3F && l_sw_en === 1 && l_focus === 1, "R9 legacy layout",
          int'({l_focus, l_sw_en, l_spur}), 'h33F);
    check(intr === 1'b1, "R1 intr after enable", int'(intr), 1);

    do_ack();
    check(ack_vec === 8'h45 && intr === 0, "R2 grant 45", int'(ack_vec), 'h45);
    do_req(8'h43);
    check(intr === 1'b0, "R1 same class in service", int'(intr), 0);
    do_req(8'h52);
    check(intr === 1'b1, "R1 higher class", int'(intr), 1);

    // R3 masking race
    do_wr(2'd0, 16'h0050);
    check(intr === 1'b0, "R3 masked by tpr", int'(intr), 0);
    do_ack();
    check(ack_vec === 8'h30, "R3 spurious on race", int'(ack_vec), 'h30);
    do_tpr_b(8'h40);
    check(intr === 1'b1, "R3 pending kept", int'(intr), 1);

    // R7 simultaneous
    wr_en = 1; wr_sel = 2'd0; wr_data = 16'h0020; tpr_b_we = 1; tpr_b_data = 8'h70;
    step();
    check(tpr === 8'h20, "R7 port A wins", int'(tpr), 'h20);

    do_ack();
    check(ack_vec === 8'h52, "R2 grant 52", int'(ack_vec), 'h52);
    do_wr(2'd2, 16'h0);
    check(intr === 1'b0, "R6 eoi retires 52 only", int'(intr), 0);
    do_wr(2'd2, 16'h0);
    check(intr === 1'b1, "R6 eoi retires 45, R3 isr untouched", int'(intr), 1);
    do_ack();
    check(ack_vec === 8'h43, "R2 grant 43", int'(ack_vec), 'h43);
    do_wr(2'd2, 16'h0);
    do_wr(2'd2, 16'h0);
    check(intr === 1'b0, "R6 eoi on empty", int'(intr), 0);

    // R5 real interrupt on the spurious vector
    do_req(8'h30);
    check(intr === 1'b1, "R5 vector 30 deliverable", int'(intr), 1);
    do_ack();
    check(ack_vec === 8'h30 && ack_valid === 1, "R5 grant 30", int'(ack_vec), 'h30);
    do_req(8'h35);
    check(intr === 1'b0, "R5 same class blocked", int'(intr), 0);
    do_req(8'h41);
    check(intr === 1'b1, "R5 higher class passes", int'(intr), 1);
    do_ack();
    do_wr(2'd2, 16'h0);
    check(intr === 1'b0, "R5 30 still blocks 35", int'(intr), 0);
    do_wr(2'd2, 16'h0);
    check(intr === 1'b1, "R5 eoi releases", int'(intr), 1);

    // random traffic against the model
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom_range(0, 9));
      req_valid = ($urandom_range(0, 2) == 0);
      req_vec = 8'($urandom_range(16, 255));
      ack = (r < 3);
      if (r == 3) begin wr_en = 1; wr_sel = 2'd2; end
      if (r == 4) begin wr_en = 1; wr_sel = 2'd0; wr_data = 16'($urandom_range(0, 255)); end
      if (r == 5) begin tpr_b_we = 1; tpr_b_data = 8'($urandom_range(0, 255)); end
      if (r == 6 && $urandom_range(0, 3) == 0) begin
        wr_en = 1; wr_sel = 2'd1; wr_data = 16'($urandom_range(0, 1023) | 'h100);
      end
      if (r == 7) begin wr_en = 1; wr_sel = 2'd3; wr_data = 16'($urandom); end
      step();
    end
    finish_run();
  end
endmodule